// File: doc/BRIEF.md
# CAN Time Stamp Counter

This block keeps a 16-bit time base for a CAN controller. It counts events from a programmable divider, which is driven by a single-cycle bit-time tick from the bit timing logic. The count divides that tick by 1, 2, 3 or 4. The counter runs freely and wraps, and software can only read it. The controller can hold it at zero through its module-reset control. Software can also clear it with a one-cycle strobe.

When a frame finishes sending or arriving, the block takes a snapshot of the counter and presents it with a one-cycle valid strobe. Message-slot storage latches the snapshot on that strobe. In loopback mode the rules change. Only a completed reception takes a snapshot, and only when a receive slot for data or remote frames can accept the frame. A completed transmission takes no snapshot in loopback mode.

Every input is synchronous to `clk`. The tick and the completion inputs are one-cycle pulses.

Top module: `can_tstamp_counter`

## Requirements
- R1: After the asynchronous reset, `ts_value`, `cap_value` and `cap_valid` are all zero.
- R2: The counter advances by one on each divided event. One divided event occurs on every (N+1)-th `bit_tick`, where N is the `presc_sel` value: 0 gives divide by 1, 1 divide by 2, 2 divide by 3 and 3 divide by 4. With no divided event the counter holds its value.
- R3: While `mod_reset` is high, `ts_value` is zero in the cycle after. The divider phase is also restarted. Counting resumes once `mod_reset` is low.
- R4: A `ts_clear` pulse makes `ts_value` zero in the next cycle. This holds even when a divided event falls in the same cycle. The pulse also restarts the divider phase.
- R5: A divided event while `ts_value` is 0xFFFF gives 0x0000. The counter does not saturate.
- R6: With `loopback` low, a pulse on `tx_done` or `rx_done` raises `cap_valid` in the next cycle. In that cycle `cap_value` equals the `ts_value` seen in the pulse cycle, before any increment in that cycle.
- R7: With `loopback` high, `tx_done` never causes a capture. `rx_done` causes a capture only when `rx_slot_avail` is high in the same cycle.
- R8: A new `presc_sel` value takes effect at the next divider rollover, or at the next clear by `mod_reset` or `ts_clear`. It does not take effect at the moment it changes.
- R9: `cap_valid` stays high for one cycle for each capturing cycle. `cap_value` keeps its last captured value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per CAN bit time (clock enable) |
| presc_sel | input | 2 | Divider select: 0..3 selects divide by 1..4 |
| mod_reset | input | 1 | Module reset control; holds the counter at zero |
| ts_clear | input | 1 | Software counter clear strobe |
| tx_done | input | 1 | Transmission completed pulse |
| rx_done | input | 1 | Reception completed pulse |
| loopback | input | 1 | Loopback mode flag |
| rx_slot_avail | input | 1 | A data/remote receive slot can take the frame |
| ts_value | output | 16 | Current counter value (read-only) |
| cap_value | output | 16 | Captured time stamp |
| cap_valid | output | 1 | One-cycle strobe marking a new capture |

## Verification
A wrong divider phase or a stale limit register shows up on `ts_value` at the next bit tick. The counter then steps one tick early or late, and the error persists in every later value, so a per-cycle comparison finds it within four ticks. A faulty capture condition or a faulty snapshot path shows on `cap_valid` or `cap_value` one cycle after the completion pulse. Loopback gating errors appear at the first transmit pulse in loopback or at the first receive pulse with no free slot.

// File: rtl/can_ts_pkg.sv
package can_ts_pkg;
  parameter int TS_W  = 16;
  parameter int SEL_W = 2;
  typedef logic [TS_W-1:0] ts_t;
endpackage

// File: rtl/can_ts_prescaler.sv
module can_ts_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             evt
);
  localparam int DIV_W = SEL_W;

  logic [DIV_W-1:0] phase_q, phase_d;
  logic [DIV_W-1:0] limit_q, limit_d;
  logic             at_limit;

  assign at_limit = (phase_q == limit_q);

  always_comb begin
    phase_d = phase_q;
    limit_d = limit_q;
    if (clr) begin
      phase_d = '0;
      limit_d = sel;
    end else if (bit_tick) begin
      if (at_limit) begin
        phase_d = '0;
        limit_d = sel;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      limit_q <= '0;
    end else begin
      phase_q <= phase_d;
      limit_q <= limit_d;
    end
  end

  assign evt = bit_tick & at_limit & ~clr;
endmodule

// File: rtl/can_ts_count.sv
module can_ts_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (evt) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/can_ts_capture.sv
module can_ts_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] now,
  input  logic         tx_done,
  input  logic         rx_done,
  input  logic         loopback,
  input  logic         rx_slot_avail,
  output logic [W-1:0] snap,
  output logic         snap_vld
);
  logic         take;
  logic [W-1:0] snap_q, snap_d;
  logic         vld_q, vld_d;

  always_comb begin
    if (loopback) take = rx_done & rx_slot_avail;
    else          take = tx_done | rx_done;
    vld_d  = take;
    snap_d = take ? now : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      snap_q <= snap_d;
      vld_q  <= vld_d;
    end
  end

  assign snap     = snap_q;
  assign snap_vld = vld_q;
endmodule

// File: rtl/can_tstamp_counter.sv
module can_tstamp_counter
  import can_ts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             mod_reset,
  input  logic             ts_clear,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             loopback,
  input  logic             rx_slot_avail,
  output logic [TS_W-1:0]  ts_value,
  output logic [TS_W-1:0]  cap_value,
  output logic             cap_valid
);
  logic clr;
  logic cnt_evt;
  ts_t  cur;

  assign clr = mod_reset | ts_clear;

  can_ts_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sel(presc_sel),
    .clr(clr), .evt(cnt_evt)
  );

  can_ts_count #(.W(TS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt(cnt_evt), .value(cur)
  );

  can_ts_capture #(.W(TS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .now(cur), .tx_done(tx_done), .rx_done(rx_done),
    .loopback(loopback), .rx_slot_avail(rx_slot_avail),
    .snap(cap_value), .snap_vld(cap_valid)
  );

  assign ts_value = cur;
endmodule

// File: rtl/can_tstamp_counter_chk.sv
module can_tstamp_counter_chk
  import can_ts_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             mod_reset,
  input logic             ts_clear,
  input logic             tx_done,
  input logic             rx_done,
  input logic             loopback,
  input logic             rx_slot_avail,
  input logic [TS_W-1:0]  ts_value,
  input logic [TS_W-1:0]  cap_value,
  input logic             cap_valid
);
  AST_HOLD_IN_MODRST: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset |=> ts_value == '0); // R3

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clear |=> ts_value == '0); // R4

  AST_STEP_OR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_reset && !ts_clear) |=>
      (ts_value == $past(ts_value) || ts_value == TS_W'($past(ts_value) + 1'b1))); // R5

  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !mod_reset && !ts_clear) |=> $stable(ts_value)); // R2

  AST_NORMAL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!loopback && (tx_done || rx_done)) |=> (cap_valid && cap_value == $past(ts_value))); // R6

  AST_LOOPBACK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && !(rx_done && rx_slot_avail)) |=> !cap_valid); // R7

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> cap_value == $past(cap_value) || $past(cap_valid) || $past(!rst_n)); // R9
endmodule

bind can_tstamp_counter can_tstamp_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mod_reset(mod_reset),
  .ts_clear(ts_clear), .tx_done(tx_done), .rx_done(rx_done), .loopback(loopback),
  .rx_slot_avail(rx_slot_avail), .ts_value(ts_value), .cap_value(cap_value),
  .cap_valid(cap_valid)
);

// File: tb/test_can_tstamp_counter.sv
`timescale 1ns/1ps
module test_can_tstamp_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic [1:0]  presc_sel = 2'd0;
  logic        mod_reset = 1'b0;
  logic        ts_clear = 1'b0;
  logic        tx_done = 1'b0;
  logic        rx_done = 1'b0;
  logic        loopback = 1'b0;
  logic        rx_slot_avail = 1'b0;
  logic [15:0] ts_value;
  logic [15:0] cap_value;
  logic        cap_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_ts = '0;
  logic [1:0]  m_ph = '0;
  logic [1:0]  m_lim = '0;
  logic        m_cv = 1'b0;
  logic [15:0] m_cval = '0;

  always #2 clk = ~clk;

  can_tstamp_counter i_can_tstamp_counter (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .presc_sel(presc_sel),
    .mod_reset(mod_reset), .ts_clear(ts_clear), .tx_done(tx_done), .rx_done(rx_done),
    .loopback(loopback), .rx_slot_avail(rx_slot_avail),
    .ts_value(ts_value), .cap_value(cap_value), .cap_valid(cap_valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected next state from the requirements
  task automatic model_step();
    logic clr, evt, take;
    clr  = mod_reset | ts_clear;
    evt  = bit_tick && (m_ph == m_lim) && !clr;
    take = loopback ? (rx_done & rx_slot_avail) : (tx_done | rx_done);
    m_cv = take;
    if (take) m_cval = m_ts;
    if (clr) begin
      m_ph = '0; m_lim = presc_sel;
    end else if (bit_tick) begin
      if (m_ph == m_lim) begin m_ph = '0; m_lim = presc_sel; end
      else m_ph = m_ph + 2'd1;
    end
    if (clr) m_ts = '0;
    else if (evt) m_ts = m_ts + 16'd1;
  endtask

  // inputs are already set; clock one edge and compare at the next negedge
  task automatic cycle(input string tag);
    string ctag;
    model_step();
    @(negedge clk);
    ctag = loopback ? "R7" : "R6";
    check(tag, ts_value, m_ts);
    check(ctag, {15'd0, cap_valid}, {15'd0, m_cv});
    check("R9", cap_value, m_cval);
  endtask

  task automatic idle_inputs();
    bit_tick = 0; mod_reset = 0; ts_clear = 0; tx_done = 0; rx_done = 0;
  endtask

  initial begin
    #760000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", ts_value, 16'd0);
    check("R1", cap_value, 16'd0);
    check("R1", {15'd0, cap_valid}, 16'd0);
    rst_n = 1'b1;

    // R2: divide by 3, ticks every cycle
    presc_sel = 2'd2; mod_reset = 1; cycle("R3");
    idle_inputs(); bit_tick = 1;
    for (int i = 0; i < 12; i++) cycle("R2");
    check("R2", ts_value, 16'd4);

    // R8: change select mid-phase; takes effect at rollover
    presc_sel = 2'd0;
    for (int i = 0; i < 8; i++) cycle("R8");

    // R4: clear coinciding with an event
    presc_sel = 2'd0; ts_clear = 1; cycle("R4");
    check("R4", ts_value, 16'd0);
    ts_clear = 0;

    // R3: hold during module reset with ticks
    mod_reset = 1;
    for (int i = 0; i < 5; i++) cycle("R3");
    check("R3", ts_value, 16'd0);
    mod_reset = 0;

    // R5: wrap at divide by 1
    for (int i = 0; i < 65535; i++) cycle("R5");
    check("R5", ts_value, 16'hFFFF);
    rx_done = 1; cycle("R5");
    check("R5", ts_value, 16'h0000);
    check("R6", cap_value, 16'hFFFF);
    rx_done = 0;

    // R7: loopback transmit never captures, receive needs a slot
    bit_tick = 0; loopback = 1; tx_done = 1; cycle("R7");
    check("R7", {15'd0, cap_valid}, 16'd0);
    tx_done = 0; rx_done = 1; rx_slot_avail = 0; cycle("R7");
    check("R7", {15'd0, cap_valid}, 16'd0);
    rx_slot_avail = 1; cycle("R7");
    check("R7", {15'd0, cap_valid}, 16'd1);
    idle_inputs(); loopback = 0;

    // R6/R9 single pulse then hold
    tx_done = 1; bit_tick = 1; cycle("R6");
    tx_done = 0; cycle("R9");
    check("R9", {15'd0, cap_valid}, 16'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit_tick      = ($urandom % 2) == 0;
      if ($urandom % 16 == 0) presc_sel = 2'($urandom);
      mod_reset     = ($urandom % 50) == 0;
      ts_clear      = ($urandom % 33) == 0;
      tx_done       = ($urandom % 10) == 0;
      rx_done       = ($urandom % 10) == 0;
      if ($urandom % 64 == 0) loopback = ~loopback;
      rx_slot_avail = ($urandom % 2) == 0;
      cycle("R2");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule